// File: doc/BRIEF.md
# Key Matrix Port Readback

This block produces the value a processor sees when it reads the data register of a general-purpose port wired to a key matrix. Eight column lines sit in the upper byte of the port and seven row lines in the lower byte. Bit 0 is an ordinary pin that has nothing to do with the keys. Each line has a two-bit direction field in the port configuration word. A line set to output shows the level that software wrote. A line that software drives low also pulls low every line on the other axis that meets it at a pressed key.

The configuration word, the written data word and the 8x8 key-pressed map are all sampled into registers on the clock. The read value is built combinationally from those registers, so the key map reaches the output one cycle after it is presented, without glitches. A read is a one-beat response stream. `rsp_valid` follows the read strobe `req_valid` in the same cycle, and `rsp_data` is valid with it. While a response is offered but not accepted (`rsp_valid` high, `rsp_ready` low), the sampling registers hold their contents, so `rsp_data` cannot change. The requester keeps `req_valid` high until `rsp_ready` is seen.

Top module: `kp_readback`

## Requirements
- R1: While `rst_n` is low the sampled configuration, data and key map are all zero, so the readback is 16'hFFFE.
- R2: Inputs reach `rsp_data` one clock edge after they are presented and never in the same cycle. `rsp_valid` equals `req_valid` in every cycle.
- R3: While `rsp_valid` is high and `rsp_ready` is low, no input is sampled and `rsp_data` holds its value. Sampling resumes on the first edge with `rsp_ready` high.
- R4: Readback bit 0 always equals written bit 0. Configuration bits [1:0] and every key in row 0 have no effect on the readback.
- R5: Line i is controlled by configuration bits [2i+1:2i]. Only the code 2'b01 makes it an output. Codes 2'b00, 2'b10 and 2'b11 all behave as a non-driving line.
- R6: A row r (1..7) set to output reads exactly written bit r. Column drive and keys do not change it.
- R7: A column c set to output reads written bit 8+c. It reads 0 anyway when some output row driven low has a pressed key at its crossing with c.
- R8: A non-output row r reads 1 unless some output column driven low has a pressed key at its crossing with r, in which case it reads 0.
- R9: A non-output column c reads 1 unless some output row driven low has a pressed key at its crossing with c, in which case it reads 0.
- R10: A line driven high as an output pulls down no other line, whatever keys are pressed.
- R11: Key map bit c*8+r means the key at column c (data bit 8+c) and row r (data bit r) is pressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in | input | 32 | Port configuration, two-bit direction field per data bit |
| wdata_in | input | 16 | Data word last written by software |
| keys_in | input | 64 | Key-pressed map, bit c*8+r for column c, row r |
| req_valid | input | 1 | Read strobe, held until accepted |
| rsp_ready | input | 1 | Consumer accepts the read response |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 16 | Composed port readback value |

## Verification
The checker assumes that every input present at one clock edge while no stall is active is the state the readback reflects after that edge. It also assumes that a stalled response stays stalled only while `rsp_ready` is low, not while the requester drops its strobe. The stimulus changes inputs only on falling edges. It keeps `req_valid` high whenever `rsp_ready` is held low, and it applies reset only with `rsp_ready` high, so every property sees a clean sample-then-compose sequence. The stimulus also covers both orders of conflict, a row overriding a column and a column overriding a row, and keys on row 0.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    LINE_IN  = 2'b00,
    LINE_OUT = 2'b01,
    LINE_IRQ = 2'b10,
    LINE_RSV = 2'b11
  } line_mode_e;

  // Only the output code lets a line assert its written level.
  function automatic logic mode_drives(input logic [MODE_W-1:0] field);
    return line_mode_e'(field) == LINE_OUT;
  endfunction
endpackage

// File: rtl/kp_sample.sv
module kp_sample #(
  parameter int CFG_W  = 32,
  parameter int DATA_W = 16,
  parameter int KEY_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [CFG_W-1:0]  cfg_d,
  input  logic [DATA_W-1:0] wd_d,
  input  logic [KEY_W-1:0]  key_d,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [DATA_W-1:0] wd_q,
  output logic [KEY_W-1:0]  key_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      wd_q  <= '0;
      key_q <= '0;
    end else if (!hold) begin
      cfg_q <= cfg_d;
      wd_q  <= wd_d;
      key_q <= key_d;
    end
  end
endmodule

// File: rtl/kp_line_decode.sv
module kp_line_decode
  import kp_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int CFG_W    = MODE_W * NUM_LINES
) (
  input  logic [CFG_W-1:0]     cfg,
  output logic [NUM_LINES-1:0] drive
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign drive[i] = mode_drives(cfg[i*MODE_W +: MODE_W]);
  end
endmodule

// File: rtl/kp_pulldown.sv
module kp_pulldown #(
  parameter int NUM_COLS = 8,
  parameter int NUM_ROWS = 8,
  localparam int KEY_W   = NUM_COLS * NUM_ROWS
) (
  input  logic [KEY_W-1:0]    key,
  input  logic [NUM_COLS-1:0] col_low,
  input  logic [NUM_ROWS-1:0] row_low,
  output logic [NUM_COLS-1:0] col_pull,
  output logic [NUM_ROWS-1:0] row_pull
);
  // Transposed view: one column mask per row.
  logic [NUM_ROWS-1:0][NUM_COLS-1:0] key_by_row;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_tr_row
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_tr_col
      assign key_by_row[r][c] = key[c*NUM_ROWS + r];
    end
    assign row_pull[r] = |(col_low & key_by_row[r]);
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign col_pull[c] = |(row_low & key[c*NUM_ROWS +: NUM_ROWS]);
  end
endmodule

// File: rtl/kp_readback.sv
module kp_readback
  import kp_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int NUM_ROWS = 8,
  localparam int DATA_W  = NUM_ROWS + NUM_COLS,
  localparam int CFG_W   = MODE_W * DATA_W,
  localparam int KEY_W   = NUM_COLS * NUM_ROWS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [KEY_W-1:0]  keys_in,
  input  logic              req_valid,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic              stall;
  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_W-1:0] wd_q;
  logic [KEY_W-1:0]  key_q;
  logic [DATA_W-1:0] drive;
  logic [NUM_ROWS-1:0] row_drv, row_drv_eff, row_low, row_pull;
  logic [NUM_COLS-1:0] col_drv, col_low, col_pull;
  logic row0_unused;

  assign rsp_valid = req_valid;
  assign stall     = req_valid & ~rsp_ready;

  kp_sample #(.CFG_W(CFG_W), .DATA_W(DATA_W), .KEY_W(KEY_W)) u_sample (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (stall),
    .cfg_d (cfg_in),
    .wd_d  (wdata_in),
    .key_d (keys_in),
    .cfg_q (cfg_q),
    .wd_q  (wd_q),
    .key_q (key_q)
  );

  kp_line_decode #(.NUM_LINES(DATA_W)) u_decode (
    .cfg   (cfg_q),
    .drive (drive)
  );

  assign row_drv     = drive[NUM_ROWS-1:0];
  assign col_drv     = drive[DATA_W-1:NUM_ROWS];
  // Line 0 is a plain pin: it never acts as a scan row.
  assign row_drv_eff = {row_drv[NUM_ROWS-1:1], 1'b0};
  assign row_low     = row_drv_eff & ~wd_q[NUM_ROWS-1:0];
  assign col_low     = col_drv & ~wd_q[DATA_W-1:NUM_ROWS];

  kp_pulldown #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_pull (
    .key      (key_q),
    .col_low  (col_low),
    .row_low  (row_low),
    .col_pull (col_pull),
    .row_pull (row_pull)
  );

  assign rsp_data[0] = wd_q[0];
  assign row0_unused = row_drv[0] ^ row_pull[0];

  // Rows resolve last: a driven row shows its own level unconditionally.
  for (genvar r = 1; r < NUM_ROWS; r++) begin : g_row
    assign rsp_data[r] = row_drv[r] ? wd_q[r] : ~row_pull[r];
  end

  // Columns can still be pulled low by a row driven low.
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign rsp_data[NUM_ROWS+c] =
      (col_drv[c] ? wd_q[NUM_ROWS+c] : 1'b1) & ~col_pull[c];
  end
endmodule

// File: rtl/kp_readback_chk.sv
module kp_readback_chk #(
  parameter int NUM_COLS = 8,
  parameter int NUM_ROWS = 8,
  localparam int DATA_W  = NUM_ROWS + NUM_COLS,
  localparam int CFG_W   = 2 * DATA_W,
  localparam int KEY_W   = NUM_COLS * NUM_ROWS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CFG_W-1:0]  cfg_in,
  input logic [DATA_W-1:0] wdata_in,
  input logic [KEY_W-1:0]  keys_in,
  input logic              req_valid,
  input logic              rsp_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data
);
  logic stall;
  logic chk_unused;
  assign stall      = rsp_valid && !rsp_ready;
  assign chk_unused = req_valid ^ cfg_in[0] ^ cfg_in[1];

  // R3
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(rsp_data));

  // R4
  bit0_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> rsp_data[0] == $past(wdata_in[0]));

  for (genvar r = 1; r < NUM_ROWS; r++) begin : g_row
    // R6
    out_row_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && cfg_in[2*r +: 2] == 2'b01) |=> rsp_data[r] == $past(wdata_in[r]));
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    // R7
    out_col_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && cfg_in[2*(NUM_ROWS+c) +: 2] == 2'b01 && !wdata_in[NUM_ROWS+c])
        |=> !rsp_data[NUM_ROWS+c]);
    // R9
    idle_col_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && cfg_in[2*(NUM_ROWS+c) +: 2] != 2'b01 &&
       keys_in[c*NUM_ROWS +: NUM_ROWS] == '0) |=> rsp_data[NUM_ROWS+c]);
  end
endmodule

bind kp_readback kp_readback_chk #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_chk (.*);

// File: tb/kp_readback_bench.sv
module kp_readback_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_in = '0;
  logic [15:0] wdata_in = 16'h0001;
  logic [63:0] keys_in = '1;
  logic        req_valid = 1'b1;
  logic        rsp_ready = 1'b1;
  logic        rsp_valid;
  logic [15:0] rsp_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  kp_readback u_kp_readback (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .wdata_in(wdata_in),
    .keys_in(keys_in), .req_valid(req_valid), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [31:0] cfg;
    logic [15:0] wd;
    logic [63:0] keys;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{"R4 ", 32'h0000_0000, 16'h0001, 64'h0, 16'hFFFF},                       // R4 bit0 high
    '{"R8 ", 32'h0000_0000, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFE},   // R8 nothing drives
    '{"R8 ", 32'h0001_0000, 16'h0000, 64'h8, 16'hFEF6},                       // R8 col0 low, key c0r3
    '{"R10", 32'h0001_0000, 16'h0100, 64'h8, 16'hFFFE},                       // R10 col0 high
    '{"R9 ", 32'h0000_0010, 16'h0000, 64'h0000_0400_0000_0000, 16'hDFFA},   // R9 row2 low, key c5r2
    '{"R7 ", 32'h0400_0010, 16'h2000, 64'h0000_0400_0000_0000, 16'hDFFA},   // R7 row wins over high col
    '{"R6 ", 32'h0400_0010, 16'h0004, 64'h0000_0400_0000_0000, 16'hDFFE},   // R6 row high vs low col
    '{"R5 ", 32'h000E_0008, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFE},   // R5 codes 10/11 inert
    '{"R4 ", 32'h0001_0001, 16'h0001, 64'h1, 16'hFEFF},                       // R4 row-0 key ignored
    '{"R11", 32'h4000_0000, 16'h0000, 64'h0200_0000_0000_8000, 16'h7FFC},   // R11 key map orientation
    '{"R8 ", 32'h0005_0000, 16'h0000, 64'h0000_0000_0040_1002, 16'hFCEC}    // R8 two columns low
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] c, input logic [15:0] w, input logic [63:0] k);
    @(negedge clk);
    cfg_in = c; wdata_in = w; keys_in = k;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hung expected finished");
    finish_run();
  end

  initial begin
    // R1 reset state, inputs nonzero while held in reset
    repeat (3) @(posedge clk);
    #1 check("R1", rsp_data, 16'hFFFE);
    check("R2", {15'd0, rsp_valid}, 16'd1);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].cfg, VECS[i].wd, VECS[i].keys);
      @(posedge clk); #1;
      check(string'(VECS[i].tag), rsp_data, VECS[i].exp);
    end

    // R2 one-edge latency: new inputs not visible before the edge
    drive(32'h0, 16'h0001, 64'h0);
    #1 check("R2", rsp_data, 16'hFCEC);
    @(posedge clk); #1 check("R2", rsp_data, 16'hFFFF);

    // R3 stall freezes sampling
    @(negedge clk);
    rsp_ready = 1'b0;
    cfg_in = 32'h0001_0000; wdata_in = 16'h0000; keys_in = 64'h8;
    @(posedge clk); #1 check("R3", rsp_data, 16'hFFFF);
    @(posedge clk); #1 check("R3", rsp_data, 16'hFFFF);
    @(negedge clk) rsp_ready = 1'b1;
    @(posedge clk); #1 check("R3", rsp_data, 16'hFEF6);

    // R2 valid follows strobe in the same cycle
    @(negedge clk) req_valid = 1'b0;
    #1 check("R2", {15'd0, rsp_valid}, 16'd0);
    @(negedge clk) req_valid = 1'b1;
    #1 check("R2", {15'd0, rsp_valid}, 16'd1);

    // R1 reset mid-run clears sampled state at once
    @(negedge clk) rst_n = 1'b0;
    #1 check("R1", rsp_data, 16'hFFFE);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check("R1", rsp_data, 16'hFEF6);

    finish_run();
  end
endmodule